// File: doc/BRIEF.md
# Stepped Volume Ramp Controller

This block sits on the host side of a three-wire serial control link to an audio front end. It moves a 5-bit attenuator code from its present value toward a requested target, one step per control frame. For every step it hands a complete 16-bit control word to a separate serial shifter over a valid/ready interface. In every word, the control fields other than volume are held at fixed playback settings. Consecutive words are spaced at least a programmable number of system clocks apart. At the default this is 0.25 ms at 100 MHz.

The codes just above zero sit in the attenuator's silent region. Stepping through them only produces clicks, so the ramp never emits them. Going up from 0, the first code sent is the lowest audible code. Going down, the code after the lowest audible code is 0. A requested target inside the silent region is treated as 0. The target input is a plain level. It is read again each time a step is due, so a changed target redirects a ramp that is already running. The ramp continues from the code already reached.

The output word is `frm_data`. It is offered with `frm_valid` and taken on a clock edge where `frm_ready` is high. The shifter may hold `frm_ready` low for as long as it needs. While it does, the word and `frm_valid` stay frozen, and no further step is computed. The ramp simply pauses. Back-pressure can stretch the spacing between words but can never shorten it.

Top module: `vramp_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises with target 0, `frm_valid` is 0, `cur_code` is 0 and `done` is 0.
- R2: Every offered word carries bit positions 0 to 10 as follows: bit 0 = 0, bit 1 = narrow-filter parameter (default 0), bit 2 = 1, bit 3 = 1, bit 4 = 1, bit 5 = 0, bit 6 = digital-input parameter (default 0), bit 7 = 1, bit 8 = 1, bit 9 = 0, bit 10 = 0. With the defaults, bits 10:0 read 0x19C.
- R3: The volume code sits in bits 15:11, with weight 1 at bit 11. When the target is above the current code, the next word carries the current code plus 1, except that from 0 it carries 7. The code reaches any target up to 31.
- R4: When the target is below the current code, the next word carries the current code minus 1, except that from 7 it carries 0.
- R5: No word ever carries a code from 1 to 6. A target from 1 to 6 is handled exactly as a target of 0.
- R6: Two successive words are first offered at least PERIOD_CLKS cycles apart. They are exactly PERIOD_CLKS apart when the earlier word was taken in its first cycle and the target did not change in between.
- R7: While `frm_valid` is high and `frm_ready` is low, `frm_valid` stays high and `frm_data` does not change.
- R8: A target change during a ramp takes effect at the next step. Stepping continues from the code already sent, in the new direction if needed, and settles on the new target.
- R9: `done` is high for exactly the one cycle after a word is taken whose code equals the effective target at that edge. It is low otherwise.
- R10: No word is offered while the current code equals the effective target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tgt_code | input | 5 | Requested volume code, read at each step |
| frm_valid | output | 1 | A control word is on offer |
| frm_ready | input | 1 | Shifter accepts the offered word on this edge |
| frm_data | output | 16 | Control word, bit k is frame position k |
| cur_code | output | 5 | Volume code of the most recently issued word |
| done | output | 1 | One-cycle pulse when the final word of a ramp is taken |

## Verification
Suppose the stored current code is corrupted. The very next word then shows a volume field that is not one legal step from the last one, or a code inside the silent region. That appears within one frame period. A pacing timer that is stuck or reloads wrongly shows as two rising edges of `frm_valid` closer than PERIOD_CLKS. It can also show as a continuous ramp whose spacing differs from PERIOD_CLKS, or as a ramp that never completes. A handshake register that drops early shows on the first stalled cycle, as a word that changes or vanishes before `frm_ready` rises. A wrong completion compare shows one cycle after the final handshake, as a missing or extra `done` pulse.

// File: rtl/vramp_pkg.sv
package vramp_pkg;
  localparam int VOL_W   = 5;
  localparam int FRAME_W = 16;

  typedef logic [VOL_W-1:0] vol_t;

  // Packed MSB first: vol lands on bits 15:11, weight 1 at bit 11.
  typedef struct packed {
    vol_t vol;
    logic spk_off;
    logic lmute;
    logic line_off;
    logic rec_off;
    logic filt_sel;
    logic filt_rec;
    logic alc_off;
    logic mic_off;
    logic chg_off;
    logic narrow;
    logic lead;
  } frame_t;
endpackage

// File: rtl/vramp_stepper.sv
module vramp_stepper
  import vramp_pkg::*;
#(
  parameter int GAP_HI = 6
) (
  input  vol_t cur,
  input  vol_t tgt_raw,
  output vol_t tgt_eff,
  output logic want,
  output vol_t nxt
);
  generate
    if (GAP_HI > 0) begin : g_skip
      localparam vol_t FLOOR = vol_t'(GAP_HI + 1);

      always_comb begin
        if (tgt_raw != '0 && tgt_raw < FLOOR) tgt_eff = '0;
        else                                  tgt_eff = tgt_raw;
      end

      always_comb begin
        if (tgt_eff > cur)      nxt = (cur == '0)    ? FLOOR : cur + vol_t'(1);
        else if (tgt_eff < cur) nxt = (cur == FLOOR) ? '0    : cur - vol_t'(1);
        else                    nxt = cur;
      end
    end else begin : g_plain
      assign tgt_eff = tgt_raw;

      always_comb begin
        if (tgt_eff > cur)      nxt = cur + vol_t'(1);
        else if (tgt_eff < cur) nxt = cur - vol_t'(1);
        else                    nxt = cur;
      end
    end
  endgenerate

  assign want = (cur != tgt_eff);
endmodule

// File: rtl/vramp_pacer.sv
module vramp_pacer #(
  parameter int PERIOD_CLKS = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic open
);
  localparam int CW = (PERIOD_CLKS > 1) ? $clog2(PERIOD_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD_CLKS - 1);

  logic [CW-1:0] cnt;

  // Saturates at LAST; starts saturated so the first step is not delayed.
  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= LAST;
    else if (restart)    cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + CW'(1);
  end

  assign open = (cnt == LAST);
endmodule

// File: rtl/vramp_framer.sv
module vramp_framer
  import vramp_pkg::*;
#(
  parameter bit NARROW_LPF = 1'b0,
  parameter bit DIGITAL_PB = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  vol_t               code_in,
  input  logic               frm_ready,
  output logic               frm_valid,
  output logic [FRAME_W-1:0] frm_data,
  output vol_t               cur_code
);
  vol_t   code_q;
  logic   valid_q;
  frame_t word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q  <= '0;
      valid_q <= 1'b0;
    end else if (load) begin
      code_q  <= code_in;
      valid_q <= 1'b1;
    end else if (valid_q && frm_ready) begin
      valid_q <= 1'b0;
    end
  end

  always_comb begin
    word = '{vol: code_q, spk_off: 1'b0, lmute: 1'b0, line_off: 1'b1,
             rec_off: 1'b1, filt_sel: DIGITAL_PB, filt_rec: 1'b0,
             alc_off: 1'b1, mic_off: 1'b1, chg_off: 1'b1,
             narrow: NARROW_LPF, lead: 1'b0};
  end

  assign frm_data  = word;
  assign frm_valid = valid_q;
  assign cur_code  = code_q;
endmodule

// File: rtl/vramp_ctrl.sv
module vramp_ctrl
  import vramp_pkg::*;
#(
  parameter int PERIOD_CLKS = 25000,
  parameter int GAP_HI      = 6,
  parameter bit NARROW_LPF  = 1'b0,
  parameter bit DIGITAL_PB  = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  tgt_code,
  output logic        frm_valid,
  input  logic        frm_ready,
  output logic [15:0] frm_data,
  output logic [4:0]  cur_code,
  output logic        done
);
  vol_t cur_w, tgt_eff, nxt;
  logic want, open, issue, valid_w, done_q;

  vramp_stepper #(.GAP_HI(GAP_HI)) u_step (
    .cur(cur_w), .tgt_raw(tgt_code), .tgt_eff(tgt_eff), .want(want), .nxt(nxt)
  );

  vramp_pacer #(.PERIOD_CLKS(PERIOD_CLKS)) u_pace (
    .clk(clk), .rst_n(rst_n), .restart(issue), .open(open)
  );

  // A step needs an expired period, an empty output slot and a pending move.
  assign issue = open && !valid_w && want;

  vramp_framer #(.NARROW_LPF(NARROW_LPF), .DIGITAL_PB(DIGITAL_PB)) u_frm (
    .clk(clk), .rst_n(rst_n), .load(issue), .code_in(nxt),
    .frm_ready(frm_ready), .frm_valid(valid_w), .frm_data(frm_data),
    .cur_code(cur_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= valid_w && frm_ready && (cur_w == tgt_eff);
  end

  assign frm_valid = valid_w;
  assign cur_code  = cur_w;
  assign done      = done_q;
endmodule

// File: rtl/vramp_ctrl_chk.sv
module vramp_ctrl_chk #(
  parameter int PERIOD_CLKS = 25000,
  parameter int GAP_HI      = 6,
  parameter bit NARROW_LPF  = 1'b0,
  parameter bit DIGITAL_PB  = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  tgt_code,
  input logic        frm_valid,
  input logic        frm_ready,
  input logic [15:0] frm_data,
  input logic [4:0]  cur_code,
  input logic        done
);
  localparam logic [10:0] FIXED = {1'b0, 1'b0, 1'b1, 1'b1, DIGITAL_PB, 1'b0,
                                   1'b1, 1'b1, 1'b1, NARROW_LPF, 1'b0};
  localparam logic [4:0]  FLOOR = 5'(GAP_HI + 1);

  logic        seen_v, seen_first;
  logic [31:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_v     <= 1'b0;
      seen_first <= 1'b0;
      gap        <= '0;
    end else begin
      seen_v <= frm_valid;
      if (frm_valid && !seen_v) begin
        gap        <= 32'd1;
        seen_first <= 1'b1;
      end else if (gap < 32'(PERIOD_CLKS)) begin
        gap <= gap + 32'd1;
      end
    end
  end

  // R2
  a_r2_fixed_fields: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> frm_data[10:0] == FIXED);

  // R3 and R4: each change of the code is one legal step
  a_r3_step_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_code != $past(cur_code)) |->
      ((cur_code == $past(cur_code) + 5'd1) || (cur_code + 5'd1 == $past(cur_code)) ||
       ($past(cur_code) == 5'd0 && cur_code == FLOOR) ||
       ($past(cur_code) == FLOOR && cur_code == 5'd0)));

  a_r5_no_silent_code: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> !(frm_data[15:11] != 5'd0 && frm_data[15:11] < FLOOR));

  a_r6_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !seen_v && seen_first) |-> gap >= 32'(PERIOD_CLKS));

  a_r7_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !frm_ready) |=> frm_valid);

  a_r7_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !frm_ready) |=> $stable(frm_data));

  a_r9_done_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(frm_valid && frm_ready));
endmodule

bind vramp_ctrl vramp_ctrl_chk #(
  .PERIOD_CLKS(PERIOD_CLKS), .GAP_HI(GAP_HI),
  .NARROW_LPF(NARROW_LPF), .DIGITAL_PB(DIGITAL_PB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tgt_code(tgt_code), .frm_valid(frm_valid),
  .frm_ready(frm_ready), .frm_data(frm_data), .cur_code(cur_code), .done(done)
);

// File: tb/sim_vramp_ctrl.sv
module sim_vramp_ctrl;
  localparam int P = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  tgt = 5'd0;
  logic        frm_ready = 1'b0;
  logic        frm_valid, done;
  logic [15:0] frm_data;
  logic [4:0]  cur_code;

  int n_chk = 0;
  int n_err = 0;
  int rdy_pct = 100;
  bit ended = 1'b0;

  vramp_ctrl #(.PERIOD_CLKS(P)) u0 (
    .clk(clk), .rst_n(rst_n), .tgt_code(tgt), .frm_valid(frm_valid),
    .frm_ready(frm_ready), .frm_data(frm_data), .cur_code(cur_code), .done(done)
  );

  always #5 clk = ~clk;

  function automatic logic [4:0] san(input logic [4:0] t);
    return (t != 5'd0 && t < 5'd7) ? 5'd0 : t;
  endfunction

  function automatic logic [4:0] step_of(input logic [4:0] c, input logic [4:0] t);
    if (t > c) return (c == 5'd0) ? 5'd7 : c + 5'd1;
    if (t < c) return (c == 5'd7) ? 5'd0 : c - 5'd1;
    return c;
  endfunction

  function automatic logic [15:0] frame_of(input logic [4:0] c);
    return {c, 11'h19C};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    ended = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  // Ready drive, 2 ns after the edge
  always @(posedge clk) begin
    #2;
    if (rdy_pct >= 100) frm_ready <= 1'b1;
    else                frm_ready <= (($urandom % 100) < rdy_pct);
  end

  // Monitor with an independent reference model
  logic [4:0]  m_cur = 5'd0;
  logic [4:0]  tgt_prev = 5'd0;
  logic        pv = 1'b0, pr = 1'b0, exp_done = 1'b0;
  logic [15:0] pd = 16'd0;
  int          cyc = 0, last_iss = -1;
  bit          prev_imm = 1'b0, tgt_chg = 1'b0;

  always @(negedge clk) begin : mon
    logic [4:0] te, ec;
    if (rst_n) begin
      cyc++;
      chk(done == exp_done, "R9", done, exp_done);
      if (pv && !pr) begin
        chk(frm_valid == 1'b1, "R7", frm_valid, 1);
        chk(frm_data == pd, "R7", frm_data, pd);
      end
      if (frm_valid && !pv) begin
        te = san(tgt_prev);
        chk(te != m_cur, "R10", m_cur, te);
        ec = step_of(m_cur, te);
        chk(frm_data == frame_of(ec), (te > m_cur) ? "R3" : "R4", frm_data, frame_of(ec));
        chk(!(frm_data[15:11] inside {[1:6]}), "R5", frm_data[15:11], ec);
        chk(frm_data[10:0] == 11'h19C, "R2", frm_data[10:0], 11'h19C);
        if (last_iss >= 0) begin
          if (prev_imm && !tgt_chg) chk(cyc - last_iss == P, "R6", cyc - last_iss, P);
          else                      chk(cyc - last_iss >= P, "R6", cyc - last_iss, P);
        end
        m_cur = ec;
        last_iss = cyc;
        prev_imm = frm_ready;
        tgt_chg = 1'b0;
      end
      if (tgt != tgt_prev) tgt_chg = 1'b1;
      exp_done = frm_valid && frm_ready && (frm_data[15:11] == san(tgt));
      pv = frm_valid;
      pr = frm_ready;
      pd = frm_data;
      tgt_prev = tgt;
    end
  end

  task automatic set_tgt(input logic [4:0] v);
    @(posedge clk);
    #2;
    tgt = v;
  endtask

  task automatic settle();
    int k;
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!(!frm_valid && cur_code == san(tgt)) && k < 6000);
    chk(k < 6000, "R3", k, 6000);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      n_chk++;
      n_err++;
      $display("FAIL R6 watchdog actual=%0d expected=%0d", 150000, 0);
      finish_run();
    end
  end

  initial begin
    int cnt;
    void'($urandom(32'd2718));
    repeat (4) @(negedge clk);
    chk(frm_valid == 1'b0, "R1", frm_valid, 0);
    chk(cur_code == 5'd0, "R1", cur_code, 0);
    chk(done == 1'b0, "R1", done, 0);
    @(posedge clk);
    #2;
    rst_n = 1'b1;
    @(negedge clk);
    chk(frm_valid == 1'b0, "R1", frm_valid, 0);
    chk(cur_code == 5'd0, "R1", cur_code, 0);

    // Full ramp up and down
    set_tgt(5'd31); settle();
    chk(cur_code == 5'd31, "R3", cur_code, 31);
    set_tgt(5'd0); settle();
    chk(cur_code == 5'd0, "R4", cur_code, 0);

    // Silent-region target from 0: nothing sent
    set_tgt(5'd3);
    cnt = 0;
    repeat (4 * P) begin
      @(negedge clk);
      if (frm_valid) cnt++;
    end
    chk(cnt == 0, "R5", cnt, 0);
    chk(cnt == 0, "R10", cnt, 0);

    // Single jumps across the silent region
    set_tgt(5'd7); settle();
    chk(cur_code == 5'd7, "R3", cur_code, 7);
    set_tgt(5'd4); settle();
    chk(cur_code == 5'd0, "R5", cur_code, 0);

    // Back-pressure
    rdy_pct = 35;
    set_tgt(5'd20); settle();
    chk(cur_code == 5'd20, "R7", cur_code, 20);
    set_tgt(5'd8); settle();
    chk(cur_code == 5'd8, "R7", cur_code, 8);

    // Reversal mid-ramp
    rdy_pct = 100;
    set_tgt(5'd31);
    do @(negedge clk); while (cur_code < 5'd26);
    set_tgt(5'd9); settle();
    chk(cur_code == 5'd9, "R8", cur_code, 9);

    // Random targets, some redirected mid-ramp
    for (int i = 0; i < 16; i++) begin
      logic [4:0] t1, t2;
      t1 = 5'($urandom % 32);
      t2 = 5'($urandom % 32);
      rdy_pct = 30 + int'($urandom % 71);
      set_tgt(t1);
      repeat (int'($urandom % (P * 6))) @(negedge clk);
      set_tgt(t2); settle();
      chk(cur_code == san(t2), "R8", cur_code, san(t2));
    end

    finish_run();
  end
endmodule